// File: doc/BRIEF.md
# Serial Link Frame Lock Tracker

This block follows the framing state of a serial link receiver. Once per received frame an upstream decoder strobes a record into it. The record says whether the control field was well formed, whether the frame was either of the two fill patterns, whether it was a data frame, and what value its alternating flag bit had. From these records the block runs a three-state lock machine: unlocked, frequency locked and phase locked. It reports that machine through two lock bits, an active-low ready line and a fixed-format status word with an active-high sync-error bit. It also gives a per-frame error verdict.

The unlocked state has a long mandatory dwell, and the lock is dropped only after two bad frames in a row. A single corrupted frame therefore does not break a running link, and a link that has just been lost cannot chatter back into lock. An active-low link reset input holds the machine unlocked for as long as it is low.

Top module: `link_sync_monitor`

## Requirements
- R1: After the synchronous reset `rst`, the machine is unlocked, `frame_err` is 0 and `status_word` reads 0x47.
- R2: From unlocked, the machine moves to frequency lock only on a frame that has `is_fill0` and `ctrl_ok` high, and only after DWELL_FRAMES (default 128) earlier frames have been spent unlocked. The 129th frame after entry is the first one that can advance.
- R3: From frequency lock, a frame with `is_fill1` and `ctrl_ok` high moves the machine to phase lock. Fill-0 frames and data frames leave frequency lock and phase lock unchanged.
- R4: In either locked state, two consecutive erroneous frames (errors as defined in R7 and R8) return the machine to unlocked and restart the dwell. A single erroneous frame followed by a good one does not.
- R5: While `link_rst_n` is low, the machine is unlocked, `frame_err` is 0, the flag reference is cleared and the dwell count restarts from zero.
- R6: `lock_freq` is high in frequency lock and in phase lock. `lock_phase` is high only in phase lock. `link_ready_n` is low exactly when `lock_freq` is high.
- R7: One cycle after each strobed frame, `frame_err` gives that frame's verdict. The verdict is 1 if `ctrl_ok` was low. The verdict is not latched: a later good frame clears it.
- R8: When `flag_chk_en` is high, a data frame whose `flag` equals the flag of the previous data frame is erroneous. After the machine enters unlocked, the first data frame is never erroneous for this reason. When `flag_chk_en` is low, the flag is not checked.
- R9: `status_word` reads 0x43 while locked (frequency or phase) and 0x47 while unlocked. Bit 2 is the active-high sync-error bit.
- R10: Cycles with `frame_valid` low change neither the state, nor `frame_err`, nor the dwell count, whatever the other frame inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_rst_n | input | 1 | Active-low link reset, holds the machine unlocked |
| flag_chk_en | input | 1 | Enables flag alternation checking on data frames |
| frame_valid | input | 1 | Strobe: one received frame record this cycle |
| ctrl_ok | input | 1 | Control field of the frame is well formed |
| is_fill0 | input | 1 | Frame is the first fill pattern |
| is_fill1 | input | 1 | Frame is the second fill pattern |
| is_data | input | 1 | Frame carries user data |
| flag | input | 1 | Alternating flag bit of the frame |
| frame_err | output | 1 | Verdict of the most recent frame |
| lock_freq | output | 1 | Frequency (or phase) locked |
| lock_phase | output | 1 | Phase locked |
| link_ready_n | output | 1 | Active-low link ready |
| status_word | output | 8 | Status word, sync error at bit 2 |

## Verification
A directed pass first walks the exact dwell boundary: 128 fill-0 frames must leave the machine unlocked and the 129th must lock it. It then sends an isolated bad frame and a bad pair. These separate the two-in-a-row loss rule from a drop on a single error. Flag sequences that repeat, alternate, and run straight after a lock loss separate the alternation check, its re-arming and its enable. After that, long seeded random runs mix fill, data and corrupted frames, garbage on idle cycles and occasional link resets, and every frame is compared against a bench model.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        LS_UNLOCKED = 2'd0,
        LS_FREQ     = 2'd1,
        LS_PHASE    = 2'd2
    } lock_state_e;

    localparam int          DWELL_DEFAULT   = 128;
    localparam int          STATUS_W_DEF    = 8;
    localparam int          SYNC_BIT_DEF    = 2;
    localparam logic [7:0]  STATUS_BASE_DEF = 8'h43;

    function automatic logic state_locked(lock_state_e s);
        return (s == LS_FREQ) || (s == LS_PHASE);
    endfunction

    function automatic logic state_phase(lock_state_e s);
        return s == LS_PHASE;
    endfunction

endpackage

// File: rtl/lsm_frame_check.sv
module lsm_frame_check (
    input  logic clk,
    input  logic rst,
    input  logic link_rst_n,
    input  logic frame_valid,
    input  logic ctrl_ok,
    input  logic is_data,
    input  logic flag,
    input  logic chk_en,
    input  logic drop,
    output logic err_now,
    output logic bad_prev,
    output logic frame_err
);
    logic armed_q;
    logic last_flag_q;
    logic flag_repeat;

    assign flag_repeat = chk_en && is_data && armed_q && (flag == last_flag_q);
    assign err_now     = !ctrl_ok || flag_repeat;

    always_ff @(posedge clk) begin
        if (rst || !link_rst_n) begin
            armed_q     <= 1'b0;
            last_flag_q <= 1'b0;
            bad_prev    <= 1'b0;
            frame_err   <= 1'b0;
        end else if (frame_valid) begin
            frame_err <= err_now;
            if (drop) begin
                bad_prev <= 1'b0;
                armed_q  <= 1'b0;
            end else begin
                bad_prev <= err_now;
                if (is_data) begin
                    armed_q     <= 1'b1;
                    last_flag_q <= flag;
                end
            end
        end
    end
endmodule

// File: rtl/lsm_dwell_timer.sv
module lsm_dwell_timer #(
    parameter int DWELL_FRAMES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic count_en,
    output logic done
);
    localparam int             CW    = $clog2(DWELL_FRAMES + 1);
    localparam logic [CW-1:0]  LIMIT = CW'(DWELL_FRAMES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (count_en && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/lsm_lock_fsm.sv
module lsm_lock_fsm
    import lsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        link_rst_n,
    input  logic        frame_valid,
    input  logic        ctrl_ok,
    input  logic        is_fill0,
    input  logic        is_fill1,
    input  logic        err_now,
    input  logic        bad_prev,
    input  logic        dwell_done,
    output lock_state_e state,
    output logic        drop,
    output logic        dwell_clear,
    output logic        dwell_count
);
    lock_state_e state_d;
    logic        frame_live;

    assign frame_live  = frame_valid && link_rst_n;
    assign drop        = frame_live && state_locked(state) && err_now && bad_prev;
    assign dwell_clear = !link_rst_n || drop;
    assign dwell_count = frame_live && (state == LS_UNLOCKED);

    always_comb begin
        state_d = state;
        unique case (state)
            LS_UNLOCKED: begin
                if (frame_live && dwell_done && is_fill0 && ctrl_ok)
                    state_d = LS_FREQ;
            end
            LS_FREQ: begin
                if (drop)
                    state_d = LS_UNLOCKED;
                else if (frame_live && is_fill1 && ctrl_ok)
                    state_d = LS_PHASE;
            end
            LS_PHASE: begin
                if (drop)
                    state_d = LS_UNLOCKED;
            end
            default: state_d = LS_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !link_rst_n)
            state <= LS_UNLOCKED;
        else
            state <= state_d;
    end
endmodule

// File: rtl/lsm_status_map.sv
module lsm_status_map
    import lsm_pkg::*;
#(
    parameter int                  STATUS_W    = 8,
    parameter int                  SYNC_BIT    = 2,
    parameter logic [STATUS_W-1:0] STATUS_BASE = 8'h43
) (
    input  lock_state_e         state,
    output logic                lock_freq,
    output logic                lock_phase,
    output logic                link_ready_n,
    output logic [STATUS_W-1:0] status_word
);
    logic sync_lost;

    assign lock_freq    = state_locked(state);
    assign lock_phase   = state_phase(state);
    assign link_ready_n = !lock_freq;
    assign sync_lost    = !lock_freq;

    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
        if (i == SYNC_BIT) begin : g_sync
            assign status_word[i] = sync_lost;
        end else begin : g_fixed
            assign status_word[i] = STATUS_BASE[i];
        end
    end
endmodule

// File: rtl/link_sync_monitor.sv
module link_sync_monitor
    import lsm_pkg::*;
#(
    parameter int                  DWELL_FRAMES = DWELL_DEFAULT,
    parameter int                  STATUS_W     = STATUS_W_DEF,
    parameter int                  SYNC_BIT     = SYNC_BIT_DEF,
    parameter logic [STATUS_W-1:0] STATUS_BASE  = STATUS_BASE_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                link_rst_n,
    input  logic                flag_chk_en,
    input  logic                frame_valid,
    input  logic                ctrl_ok,
    input  logic                is_fill0,
    input  logic                is_fill1,
    input  logic                is_data,
    input  logic                flag,
    output logic                frame_err,
    output logic                lock_freq,
    output logic                lock_phase,
    output logic                link_ready_n,
    output logic [STATUS_W-1:0] status_word
);
    lock_state_e state;
    logic        err_now;
    logic        bad_prev;
    logic        drop;
    logic        dwell_done;
    logic        dwell_clear;
    logic        dwell_count;

    lsm_frame_check u_check (
        .clk         (clk),
        .rst         (rst),
        .link_rst_n  (link_rst_n),
        .frame_valid (frame_valid),
        .ctrl_ok     (ctrl_ok),
        .is_data     (is_data),
        .flag        (flag),
        .chk_en      (flag_chk_en),
        .drop        (drop),
        .err_now     (err_now),
        .bad_prev    (bad_prev),
        .frame_err   (frame_err)
    );

    lsm_dwell_timer #(.DWELL_FRAMES(DWELL_FRAMES)) u_dwell (
        .clk      (clk),
        .rst      (rst),
        .clear    (dwell_clear),
        .count_en (dwell_count),
        .done     (dwell_done)
    );

    lsm_lock_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .link_rst_n  (link_rst_n),
        .frame_valid (frame_valid),
        .ctrl_ok     (ctrl_ok),
        .is_fill0    (is_fill0),
        .is_fill1    (is_fill1),
        .err_now     (err_now),
        .bad_prev    (bad_prev),
        .dwell_done  (dwell_done),
        .state       (state),
        .drop        (drop),
        .dwell_clear (dwell_clear),
        .dwell_count (dwell_count)
    );

    lsm_status_map #(
        .STATUS_W    (STATUS_W),
        .SYNC_BIT    (SYNC_BIT),
        .STATUS_BASE (STATUS_BASE)
    ) u_status (
        .state        (state),
        .lock_freq    (lock_freq),
        .lock_phase   (lock_phase),
        .link_ready_n (link_ready_n),
        .status_word  (status_word)
    );
endmodule

// File: rtl/lsm_sva.sv
module lsm_sva #(
    parameter int DWELL_FRAMES = 128,
    parameter int STATUS_W     = 8,
    parameter int SYNC_BIT     = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                link_rst_n,
    input logic                frame_valid,
    input logic                ctrl_ok,
    input logic                frame_err,
    input logic                lock_freq,
    input logic                lock_phase,
    input logic                link_ready_n,
    input logic [STATUS_W-1:0] status_word
);
    localparam int            CW  = $clog2(DWELL_FRAMES + 2);
    localparam logic [CW-1:0] SAT = CW'(DWELL_FRAMES + 1);
    localparam logic [CW-1:0] MIN = CW'(DWELL_FRAMES);

    logic [CW-1:0] unl_frames;
    logic          prev_ctl_bad;

    always_ff @(posedge clk) begin
        if (rst || !link_rst_n || lock_freq) begin
            unl_frames <= '0;
        end else if (frame_valid && unl_frames != SAT) begin
            unl_frames <= unl_frames + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !link_rst_n)
            prev_ctl_bad <= 1'b0;
        else if (frame_valid)
            prev_ctl_bad <= !ctrl_ok;
    end

    // R2: lock may only be gained after the dwell has elapsed
    a_r2_dwell_before_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_freq) |-> (unl_frames >= MIN));

    // R3: phase lock is only reached from frequency lock
    a_r3_phase_via_freq: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_phase) |-> $past(lock_freq));

    // R4: a second consecutive bad control field drops the lock
    a_r4_pair_drops_lock: assert property (@(posedge clk) disable iff (rst)
        (link_rst_n && frame_valid && !ctrl_ok && prev_ctl_bad) |=> !lock_freq);

    // R5: link reset forces the unlocked state
    a_r5_link_reset_unlocks: assert property (@(posedge clk) disable iff (rst)
        !link_rst_n |=> (!lock_freq && !frame_err));

    // R6: output decode consistency
    a_r6_ready_and_phase: assert property (@(posedge clk) disable iff (rst)
        (link_ready_n == !lock_freq) && (!lock_phase || lock_freq));

    // R7: a bad control field yields an error verdict next cycle
    a_r7_ctrl_error: assert property (@(posedge clk) disable iff (rst)
        (link_rst_n && frame_valid && !ctrl_ok) |=> frame_err);

    // R9: sync-error bit tracks the lock
    a_r9_status_bit: assert property (@(posedge clk) disable iff (rst)
        status_word[SYNC_BIT] == !lock_freq);

    // R10: idle cycles leave the verdict alone
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!frame_valid && link_rst_n) |=> $stable(frame_err));
endmodule

bind link_sync_monitor lsm_sva #(
    .DWELL_FRAMES (DWELL_FRAMES),
    .STATUS_W     (STATUS_W),
    .SYNC_BIT     (SYNC_BIT)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .link_rst_n   (link_rst_n),
    .frame_valid  (frame_valid),
    .ctrl_ok      (ctrl_ok),
    .frame_err    (frame_err),
    .lock_freq    (lock_freq),
    .lock_phase   (lock_phase),
    .link_ready_n (link_ready_n),
    .status_word  (status_word)
);

// File: tb/link_sync_monitor_tb.sv
module link_sync_monitor_tb;
    localparam int DWELL = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_rst_n = 1'b1;
    logic       flag_chk_en = 1'b0;
    logic       frame_valid = 1'b0;
    logic       ctrl_ok = 1'b1;
    logic       is_fill0 = 1'b0;
    logic       is_fill1 = 1'b0;
    logic       is_data = 1'b0;
    logic       flag = 1'b0;
    logic       frame_err;
    logic       lock_freq;
    logic       lock_phase;
    logic       link_ready_n;
    logic [7:0] status_word;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // bench model state
    int m_state = 0;
    int m_cnt   = 0;
    bit m_armed = 0;
    bit m_last  = 0;
    bit m_bad   = 0;
    bit m_err   = 0;

    always #2 clk = ~clk;

    link_sync_monitor u_dut (
        .clk          (clk),
        .rst          (rst),
        .link_rst_n   (link_rst_n),
        .flag_chk_en  (flag_chk_en),
        .frame_valid  (frame_valid),
        .ctrl_ok      (ctrl_ok),
        .is_fill0     (is_fill0),
        .is_fill1     (is_fill1),
        .is_data      (is_data),
        .flag         (flag),
        .frame_err    (frame_err),
        .lock_freq    (lock_freq),
        .lock_phase   (lock_phase),
        .link_ready_n (link_ready_n),
        .status_word  (status_word)
    );

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        check(req, "lock_freq",    int'(lock_freq),    (m_state != 0) ? 1 : 0);
        check(req, "lock_phase",   int'(lock_phase),   (m_state == 2) ? 1 : 0);
        check(req, "link_ready_n", int'(link_ready_n), (m_state == 0) ? 1 : 0);
        check(req, "status_word",  int'(status_word),  (m_state == 0) ? 'h47 : 'h43);
        check(req, "frame_err",    int'(frame_err),    int'(m_err));
    endtask

    function automatic void model_frame(bit ok, bit f0, bit f1, bit d, bit fl, bit chk);
        bit err;
        bit drop;
        err  = !ok || (chk && d && m_armed && (fl == m_last));
        drop = (m_state != 0) && err && m_bad;
        m_err = err;
        if (drop) begin
            m_state = 0; m_cnt = 0; m_armed = 0; m_bad = 0;
        end else begin
            m_bad = err;
            if (d) begin m_armed = 1; m_last = fl; end
            if (m_state == 0) begin
                if (m_cnt == DWELL && f0 && ok) m_state = 1;
                if (m_cnt < DWELL) m_cnt++;
            end else if (m_state == 1) begin
                if (f1 && ok) m_state = 2;
            end
        end
    endfunction

    function automatic void model_reset();
        m_state = 0; m_cnt = 0; m_armed = 0; m_bad = 0; m_err = 0; m_last = 0;
    endfunction

    task automatic garbage();
        ctrl_ok  = 1'($urandom);
        is_fill0 = 1'($urandom);
        is_fill1 = 1'($urandom);
        is_data  = 1'($urandom);
        flag     = 1'($urandom);
    endtask

    // one frame: strobe for a cycle, then check at the following falling edge
    task automatic send(bit ok, bit f0, bit f1, bit d, bit fl, string req);
        @(negedge clk);
        frame_valid = 1'b1;
        ctrl_ok = ok; is_fill0 = f0; is_fill1 = f1; is_data = d; flag = fl;
        model_frame(ok, f0, f1, d, fl, flag_chk_en);
        @(negedge clk);
        frame_valid = 1'b0;
        garbage();
        check_all(req);
    endtask

    task automatic idle_check(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            garbage();
        end
        check_all("R10");
    endtask

    task automatic pulse_link_reset(int n);
        @(negedge clk);
        link_rst_n = 1'b0;
        frame_valid = 1'b0;
        repeat (n) @(negedge clk);
        model_reset();
        check_all("R5");
        link_rst_n = 1'b1;
    endtask

    task automatic lock_up(string req);
        for (int i = 0; i < DWELL; i++) send(1, 1, 0, 0, 0, req);
        send(1, 1, 0, 0, 0, req);
        send(1, 0, 1, 0, 0, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2: dwell boundary, 128 frames stay unlocked, frame 129 locks
        for (int i = 0; i < DWELL; i++) send(1, 1, 0, 0, 0, "R2");
        check("R2", "still unlocked after dwell", int'(lock_freq), 0);
        send(1, 1, 0, 0, 0, "R2");
        check("R2", "locked on frame 129", int'(lock_freq), 1);

        // R3: fill0 and data keep frequency lock, fill1 moves to phase lock
        send(1, 1, 0, 0, 0, "R3");
        send(1, 0, 0, 1, 0, "R3");
        send(1, 0, 1, 0, 0, "R3");
        check("R3", "phase lock", int'(lock_phase), 1);
        send(1, 1, 0, 0, 0, "R3");

        // R7 and R4: single bad frame keeps the lock, verdict clears after
        send(0, 0, 0, 1, 1, "R7");
        check("R4", "single error keeps lock", int'(lock_freq), 1);
        send(1, 0, 0, 1, 0, "R7");
        check("R7", "verdict not latched", int'(frame_err), 0);
        idle_check(3);

        // R4: two in a row drop the lock
        send(0, 0, 0, 0, 0, "R4");
        send(0, 0, 0, 0, 0, "R4");
        check("R4", "pair drops lock", int'(lock_freq), 0);

        // R8: flag alternation
        flag_chk_en = 1'b1;
        send(1, 0, 0, 1, 1, "R8");
        send(1, 0, 0, 1, 0, "R8");
        send(1, 0, 0, 1, 1, "R8");
        send(1, 0, 0, 1, 1, "R8");
        check("R8", "repeated flag flagged", int'(frame_err), 1);
        send(1, 1, 0, 0, 1, "R8");
        send(1, 0, 0, 1, 1, "R8");
        check("R8", "repeat across fill frame", int'(frame_err), 1);
        flag_chk_en = 1'b0;
        send(1, 0, 0, 1, 1, "R8");
        check("R8", "check disabled", int'(frame_err), 0);

        // R8: re-arm after lock loss
        flag_chk_en = 1'b1;
        lock_up("R3");
        send(1, 0, 0, 1, 0, "R8");
        send(0, 0, 0, 1, 1, "R4");
        send(0, 0, 0, 1, 0, "R4");
        check("R4", "dropped", int'(lock_freq), 0);
        send(1, 0, 0, 1, 0, "R8");
        check("R8", "first data after entry not flagged", int'(frame_err), 0);

        // R5: link reset while locked, dwell restarts
        lock_up("R2");
        pulse_link_reset(2);
        for (int i = 0; i < DWELL; i++) send(1, 1, 0, 0, 0, "R5");
        check("R5", "dwell restarted", int'(lock_freq), 0);
        send(1, 1, 0, 0, 0, "R5");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int k;
            bit ok;
            bit fl;
            if (($urandom % 700) == 0) pulse_link_reset(1 + ($urandom % 3));
            if (($urandom % 200) == 0) flag_chk_en = ~flag_chk_en;
            ok = (($urandom % 24) != 0);
            k  = $urandom % 4;
            fl = (($urandom % 6) == 0) ? m_last : ~m_last;
            if (k == 0)      send(ok, 1, 0, 0, 0, "R4");
            else if (k == 1) send(ok, 0, 1, 0, 0, "R3");
            else             send(ok, 0, 0, 1, fl, "R8");
            if (($urandom % 10) == 0) idle_check(1 + ($urandom % 3));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule